// File: doc/BRIEF.md
# Bubble-collapsing stallable shift pipeline

This block is a chain of data registers, each with a valid flag, that carries items from an upstream sender to a downstream receiver in arrival order. The sender offers a word with a valid flag that need not be high every cycle. The receiver offers a ready flag. Idle input cycles enter the chain as empty slots.

Every cycle, each stage decides on its own whether to take the contents of the stage behind it. A stage moves when the receiver is ready, or when some slot at or beyond it toward the output is empty. Empty slots are therefore squeezed out even while the output is stalled. The chain can hold as many items as it has stages. Input acceptance is the enable of the first stage. The output is the last stage.

Top module: `squeeze_pipe`

## Requirements
- R1: While reset is low and after its release, all stages are empty: out_valid is 0, and in_ready is 1 even with out_ready low.
- R2: in_ready is 1 exactly when out_ready is 1 or fewer than DEPTH items are held. Items held counts accepted items minus delivered items.
- R3: Items leave in the order they were accepted, with no item lost or duplicated. An item is accepted when in_valid and in_ready are both 1 at a rising clock edge. It is delivered when out_valid and out_ready are both 1 at a rising clock edge.
- R4: With out_ready held at 0, the block accepts exactly DEPTH items, whatever idle gaps separate them, and then holds in_ready at 0.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R6: An item accepted into an empty block at edge e, with out_ready high, appears on out_valid/out_data right after edge e+DEPTH-1, and not before.
- R7: With in_valid and out_ready both held at 1, one item is accepted and, once the chain is primed, one item is delivered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Sender offers in_data |
| in_ready | output | 1 | First stage can load this cycle |
| in_data | input | WIDTH | Word from the sender |
| out_valid | output | 1 | Last stage holds an item |
| out_ready | input | 1 | Receiver takes the item this cycle |
| out_data | output | WIDTH | Word in the last stage |

## Verification
A stage whose valid flag is wrong shows up in one of two ways. It can turn in_ready wrong against the count of items held, on the same cycle. Or it can make a word appear twice, vanish or overtake another, which the ordered comparison at the next delivery exposes. An enable that fires too early or too late shifts the single-item arrival off the DEPTH-cycle mark. It also changes out_data during a stall on the very next cycle. Long stalled stretches with sparse input show whether gaps are really collapsed, because only then does the block reach full DEPTH occupancy.

// File: rtl/squeeze_pkg.sv
package squeeze_pkg;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_WIDTH = 200;
endpackage

// File: rtl/squeeze_enable.sv
// Per-stage advance decision: a stage moves when the receiver takes the
// head, or when an empty slot exists at or beyond it toward the output.
module squeeze_enable #(
  parameter int unsigned DEPTH = squeeze_pkg::DEF_DEPTH
) (
  input  logic [DEPTH-1:0] slot_full,
  input  logic             sink_take,
  output logic [DEPTH-1:0] advance
);
  logic [DEPTH:0] gap_ahead;

  assign gap_ahead[DEPTH] = 1'b0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_gap
    assign gap_ahead[i] = ~slot_full[i] | gap_ahead[i+1];
    assign advance[i]   = sink_take | gap_ahead[i];
  end
endmodule

// File: rtl/squeeze_stage.sv
// One slot: a valid flag with async clear and a data word with clock enable.
module squeeze_stage #(
  parameter int unsigned WIDTH = squeeze_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             prev_full,
  input  logic [WIDTH-1:0] prev_word,
  output logic             full,
  output logic [WIDTH-1:0] word
);
  logic full_d;

  always_comb begin
    full_d = full;
    if (load) full_d = prev_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) word <= prev_word;
  end
endmodule

// File: rtl/squeeze_pipe.sv
module squeeze_pipe #(
  parameter int unsigned DEPTH = squeeze_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = squeeze_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] slot_full;
  logic [DEPTH-1:0] advance;
  logic [WIDTH-1:0] slot_word [DEPTH];

  squeeze_enable #(.DEPTH(DEPTH)) u_enable (
    .slot_full (slot_full),
    .sink_take (out_ready),
    .advance   (advance)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             src_full;
    logic [WIDTH-1:0] src_word;
    if (i == 0) begin : g_head
      assign src_full = in_valid;
      assign src_word = in_data;
    end else begin : g_body
      assign src_full = slot_full[i-1];
      assign src_word = slot_word[i-1];
    end
    squeeze_stage #(.WIDTH(WIDTH)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (advance[i]),
      .prev_full (src_full),
      .prev_word (src_word),
      .full      (slot_full[i]),
      .word      (slot_word[i])
    );
  end

  assign in_ready  = advance[0];
  assign out_valid = slot_full[LAST];
  assign out_data  = slot_word[LAST];
endmodule

// File: rtl/squeeze_pipe_chk.sv
module squeeze_pipe_chk #(
  parameter int unsigned DEPTH = squeeze_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = squeeze_pkg::DEF_WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);
  localparam int unsigned CW = $clog2(DEPTH + 1) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] held;
  logic          take_in, take_out;

  assign take_in  = in_valid & in_ready;
  assign take_out = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held + CW'(take_in) - CW'(take_out);
  end

  a_r1_empty_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    (held == '0) |-> !out_valid);
  a_r2_room_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (held < FULL_CNT) |-> in_ready);
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (held == FULL_CNT) && !out_ready);
  a_r3_bounded_held: assert property (@(posedge clk) disable iff (!rst_n)
    held <= FULL_CNT);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  a_r7_ready_passes: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind squeeze_pipe squeeze_pipe_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/squeeze_pipe_test.sv
`timescale 1ns/1ps
module squeeze_pipe_test;
  localparam int unsigned DEPTH = 5;
  localparam int unsigned WIDTH = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [WIDTH-1:0] in_data;
  logic             out_valid;
  logic             out_ready;
  logic [WIDTH-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [WIDTH-1:0] q [$];
  int               n_acc, n_del;
  bit               prev_hold = 0;
  logic [WIDTH-1:0] prev_word;
  logic             s_out_valid;
  logic [WIDTH-1:0] s_out_data;
  logic [WIDTH-1:0] tag_ctr = '0;

  always #2.5 clk = ~clk;

  squeeze_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic bit exp_ready(int held, logic ordy);
    return (held < int'(DEPTH)) || ordy;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(input logic iv, input logic [WIDTH-1:0] d, input logic ordy);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    s_out_valid = out_valid;
    s_out_data  = out_data;
    chk(in_ready == exp_ready(q.size(), ordy), "R2 in_ready", int'(in_ready),
        int'(exp_ready(q.size(), ordy)));
    if (prev_hold)
      chk(out_valid && out_data == prev_word, "R5 stall hold", int'(out_data), int'(prev_word));
    if (out_valid && ordy) begin
      if (q.size() == 0) chk(0, "R3 extra item", int'(out_data), -1);
      else begin
        chk(out_data == q[0], "R3 order", int'(out_data), int'(q[0]));
        void'(q.pop_front());
      end
      n_del++;
    end
    if (iv && in_ready) begin
      q.push_back(d);
      n_acc++;
    end
    prev_hold = out_valid && !ordy;
    prev_word = out_data;
  endtask

  function automatic logic [WIDTH-1:0] next_tag();
    tag_ctr = tag_ctr + 1'b1;
    return tag_ctr;
  endfunction

  task automatic drain();
    for (int k = 0; k < int'(DEPTH) + 3; k++) step(1'b0, '0, 1'b1);
    chk(q.size() == 0, "R3 nothing lost", q.size(), 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'h5A17);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    repeat (2) step(1'b0, '0, 1'b0);

    // R6 single item latency
    step(1'b1, 12'h0A5, 1'b1);
    for (int j = 1; j <= int'(DEPTH); j++) begin
      step(1'b0, '0, 1'b1);
      if (j == int'(DEPTH) - 1) chk(s_out_valid == 1'b0, "R6 not early", int'(s_out_valid), 0);
      if (j == int'(DEPTH)) begin
        chk(s_out_valid == 1'b1, "R6 arrival", int'(s_out_valid), 1);
        chk(s_out_data == 12'h0A5, "R6 arrival data", int'(s_out_data), 'h0A5);
      end
    end
    drain();

    // R4 fill under stall with gaps
    n_acc = 0;
    for (int k = 0; k < 4 * int'(DEPTH); k++)
      step((k % 3) == 0, next_tag(), 1'b0);
    chk(n_acc == int'(DEPTH), "R4 stalled capacity", n_acc, DEPTH);
    step(1'b1, next_tag(), 1'b0);
    chk(in_ready == 1'b0, "R4 full blocks", int'(in_ready), 0);
    drain();

    // R7 streaming
    n_acc = 0; n_del = 0;
    for (int k = 0; k < 40; k++) step(1'b1, next_tag(), 1'b1);
    chk(n_acc == 40, "R7 accept rate", n_acc, 40);
    chk(n_del == 40 - int'(DEPTH), "R7 deliver rate", n_del, 40 - int'(DEPTH));
    drain();

    // random traffic (R2, R3, R5)
    for (int k = 0; k < 4000; k++) begin
      logic iv, ordy;
      iv   = ($urandom % 10) < 6;
      ordy = ($urandom % 10) < ((k / 500) % 2 == 0 ? 5 : 8);
      step(iv, logic'(iv) ? next_tag() : WIDTH'($urandom), ordy);
    end
    drain();

    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end
endmodule